// File: doc/BRIEF.md
# Linear Address Breakpoint Match Unit

This block watches the stream of linear addresses produced by instruction fetches and data accesses and compares every one of them, in the same cycle, against four programmable breakpoint addresses. Each breakpoint has a window length of 1, 2 or 4 bytes, which is always naturally aligned, and an access-type condition. The comparison works on linear addresses only. No address translation takes part in it.

A qualifying match sets the sticky hit flag of that breakpoint in a status word. When the breakpoint also has a local or a global enable set, the block asks for a debug trap. Software reads and writes the breakpoint addresses, the status word and the control word through an index/data register port. A protection bit in the control word can lock that port. While the bit is set, the first register access is refused, the protection bit clears itself, a flag is set and a trap is requested.

The trap request comes from a two-state machine. `ST_IDLE` is the quiet state. It moves to `ST_TRAP` ("fire") when, in the current cycle, an enabled breakpoint matches or a protected register access is refused. `ST_TRAP` drives `trap_req` high for one cycle. It stays in `ST_TRAP` if another cause arrives in that cycle. Otherwise it goes back to `ST_IDLE` ("retire").

Top module: `bp_match_unit`

## Requirements
- R1: After reset, all eight register indices read zero and `trap_req` is low.
- R2: Register indices 0 to 3 hold the full 32-bit address of breakpoints 0 to 3 and read back exactly what was written. Indices 4 and 5 read zero and ignore writes.
- R3: Index 7 is the control word. Bit 2i is the local enable and bit 2i+1 is the global enable of breakpoint i. Bits 8 and 9 are two extra enable bits with no effect on matching. Bit 13 is the protection bit. Bits 17+4i:16+4i hold the type of breakpoint i, and bits 19+4i:18+4i hold its length. Every other bit reads zero, so a write of all ones reads back 0xFFFF23FF.
- R4: The length code selects the window: 00 and 10 give exactly one byte, 01 gives 2 bytes (address bit 0 ignored), and 11 gives 4 bytes (address bits 1:0 ignored). For breakpoint address 5, the windows are {5}, {4,5} and {4..7}.
- R5: `acc_kind` is 00 for fetch, 01 for data write, 10 for data read, and 11 for no access. Type 00 matches only fetches, and only with length 00. Type 01 matches writes. Type 11 matches reads and writes. Type 10 never matches. Nothing matches when `acc_valid` is low or `acc_kind` is 11.
- R6: Index 6 is the status word. Bits 3:0 are the hit flags of breakpoints 3 to 0. A qualifying match sets its flag whether or not the breakpoint is enabled. A flag stays set until software writes the status word.
- R7: `trap_req` is high in the cycle after a qualifying match on a breakpoint whose local or global enable is set, or after a refused access. It is low in every other cycle.
- R8: While control bit 13 is set, any register read or write is refused. A refused write changes nothing, and a refused read returns zero. In the next cycle, control bit 13 is clear, status bit 13 is set and a trap is requested.
- R9: A status write stores only bits 3:0, 13, 14 and 15 (so all ones reads back 0xE00F). A hit in the same cycle as a status write still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid combinationally while `reg_rd` is high, otherwise zero |
| acc_valid | input | 1 | An access address is present this cycle |
| acc_addr | input | 32 | Linear byte address of the access |
| acc_kind | input | 2 | Access kind (see R5) |
| trap_req | output | 1 | Debug trap request |

## Verification
The bench sweeps the byte addresses 3 to 8 past a breakpoint at 5 with every length code. A design that masks the wrong address bits, or that treats code 10 as a wider window, sets a flag on a neighbouring byte. Fetch breakpoints are run with a non-zero length, and with types 10 and the no-access kind. A design that ignores the execute-length rule or decodes the type loosely produces a trap the model does not expect. The bench also writes the status word in the same cycle as a hit, sends accesses while the protection bit is set, and runs a long random stretch checked every cycle. These catch a design that lets a write erase a new hit, performs a refused write, or fails to clear the protection bit.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    localparam int NUM_BP  = 4;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = 3;

    localparam logic [SEL_W-1:0] SEL_STS  = 3'd6;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd7;

    localparam int GD_BIT  = 13;
    localparam int BD_BIT  = 13;
    localparam int FLD_LO  = 16;
    localparam int FLD_W   = 4;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'hFFFF_23FF;
    localparam logic [DATA_W-1:0] STS_MASK  = 32'h0000_E00F;

    localparam logic [1:0] KIND_FETCH = 2'b00;
    localparam logic [1:0] KIND_WRITE = 2'b01;
    localparam logic [1:0] KIND_READ  = 2'b10;
    localparam logic [1:0] KIND_NONE  = 2'b11;

    localparam logic [1:0] TY_EXEC  = 2'b00;
    localparam logic [1:0] TY_WRITE = 2'b01;
    localparam logic [1:0] TY_NEVER = 2'b10;
    localparam logic [1:0] TY_RW    = 2'b11;

    localparam logic [1:0] LEN_1  = 2'b00;
    localparam logic [1:0] LEN_2  = 2'b01;
    localparam logic [1:0] LEN_1X = 2'b10;
    localparam logic [1:0] LEN_4  = 2'b11;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } trap_st_t;
endpackage

// File: rtl/bpm_match.sv
module bpm_match
    import bpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bp_addr,
    input  logic [1:0]        bp_type,
    input  logic [1:0]        bp_len,
    input  logic              acc_valid,
    input  logic [DATA_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    output logic              hit
);
    logic [DATA_W-1:0] keep_mask;
    logic              addr_eq;
    logic              type_ok;

    always_comb begin
        unique case (bp_len)
            LEN_2:   keep_mask = ~{{(DATA_W-1){1'b0}}, 1'b1};
            LEN_4:   keep_mask = ~{{(DATA_W-2){1'b0}}, 2'b11};
            default: keep_mask = '1;
        endcase
    end

    assign addr_eq = ((acc_addr ^ bp_addr) & keep_mask) == '0;

    always_comb begin
        unique case (bp_type)
            TY_EXEC:  type_ok = (acc_kind == KIND_FETCH) && (bp_len == LEN_1);
            TY_WRITE: type_ok = (acc_kind == KIND_WRITE);
            TY_RW:    type_ok = (acc_kind == KIND_WRITE) || (acc_kind == KIND_READ);
            default:  type_ok = 1'b0;
        endcase
    end

    assign hit = acc_valid && (acc_kind != KIND_NONE) && addr_eq && type_ok;

    // R5: an execute breakpoint only fires with a one-byte length
    assert_exec_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bp_type == TY_EXEC) |-> (bp_len == LEN_1 && acc_kind == KIND_FETCH));
    // R5: the never-match type produces no hit
    assert_never_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_type == TY_NEVER) |-> !hit);
endmodule

// File: rtl/bpm_regs.sv
module bpm_regs
    import bpm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEL_W-1:0]              sel,
    input  logic                          wr,
    input  logic                          rd,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_BP-1:0]             hit,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_BP-1:0][DATA_W-1:0] bp_addr,
    output logic [NUM_BP-1:0][1:0]        bp_type,
    output logic [NUM_BP-1:0][1:0]        bp_len,
    output logic [NUM_BP-1:0]             bp_en,
    output logic                          gd_trip
);
    logic [NUM_BP-1:0][DATA_W-1:0] addr_q;
    logic [DATA_W-1:0]             ctrl_q;
    logic [DATA_W-1:0]             sts_q;
    logic [DATA_W-1:0]             sts_next;
    logic                          wr_ok;
    logic                          sts_wr;

    assign gd_trip = ctrl_q[GD_BIT] && (wr || rd);
    assign wr_ok   = wr && !gd_trip;
    assign sts_wr  = wr_ok && (sel == SEL_STS);

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        always_ff @(posedge clk) begin
            if (!rst_n)
                addr_q[i] <= '0;
            else if (wr_ok && sel == SEL_W'(i))
                addr_q[i] <= wdata;
        end
        assign bp_addr[i] = addr_q[i];
        assign bp_en[i]   = ctrl_q[2*i] || ctrl_q[2*i+1];
        assign bp_type[i] = ctrl_q[FLD_LO + FLD_W*i +: 2];
        assign bp_len[i]  = ctrl_q[FLD_LO + FLD_W*i + 2 +: 2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (gd_trip)
            ctrl_q[GD_BIT] <= 1'b0;
        else if (wr_ok && sel == SEL_CTRL)
            ctrl_q <= wdata & CTRL_MASK;
    end

    always_comb begin
        sts_next = sts_q;
        if (sts_wr)
            sts_next = wdata & STS_MASK;
        if (gd_trip)
            sts_next[BD_BIT] = 1'b1;
        sts_next[NUM_BP-1:0] = sts_next[NUM_BP-1:0] | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= '0;
        else
            sts_q <= sts_next;
    end

    always_comb begin
        rdata = '0;
        if (rd && !gd_trip) begin
            unique case (sel)
                3'd0, 3'd1, 3'd2, 3'd3: rdata = addr_q[sel[1:0]];
                SEL_STS:                rdata = sts_q;
                SEL_CTRL:               rdata = ctrl_q;
                default:                rdata = '0;
            endcase
        end
    end

    // R3: reserved control bits never become set
    assert_ctrl_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0);
    // R6: hit flags do not clear without a status write
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> ((sts_q[NUM_BP-1:0] & $past(sts_q[NUM_BP-1:0])) == $past(sts_q[NUM_BP-1:0])));
    // R8: a refused access clears protection and flags it
    assert_gd_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gd_trip |=> (!ctrl_q[GD_BIT] && sts_q[BD_BIT]));
    // R8: a refused write leaves the breakpoint addresses alone
    assert_gd_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gd_trip |=> $stable(addr_q));
endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
    import bpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic [1:0]        acc_kind,
    output logic              trap_req
);
    logic [NUM_BP-1:0][DATA_W-1:0] bp_addr;
    logic [NUM_BP-1:0][1:0]        bp_type;
    logic [NUM_BP-1:0][1:0]        bp_len;
    logic [NUM_BP-1:0]             bp_en;
    logic [NUM_BP-1:0]             hit;
    logic                          gd_trip;
    logic                          fire;
    trap_st_t                      state_q, state_d;

    bpm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (reg_sel),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .wdata   (reg_wdata),
        .hit     (hit),
        .rdata   (reg_rdata),
        .bp_addr (bp_addr),
        .bp_type (bp_type),
        .bp_len  (bp_len),
        .bp_en   (bp_en),
        .gd_trip (gd_trip)
    );

    for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
        bpm_match u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .bp_addr   (bp_addr[i]),
            .bp_type   (bp_type[i]),
            .bp_len    (bp_len[i]),
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_kind  (acc_kind),
            .hit       (hit[i])
        );
    end

    assign fire = (|(hit & bp_en)) || gd_trip;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = fire ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_d = fire ? ST_TRAP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        trap_req = (state_q == ST_TRAP);
    end

    // R7: an enabled match raises the trap next cycle
    assert_trap_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & bp_en)) |=> trap_req);
    // R7: no trap without a cause in the previous cycle
    assert_trap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(hit & bp_en)) && !gd_trip) |=> !trap_req);
    // R8: a refused access raises the trap next cycle
    assert_gd_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gd_trip |=> trap_req);
endmodule

// File: tb/tb_bp_match_unit.sv
`timescale 1ns/1ps
module tb_bp_match_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = 2'b11;
    logic        trap_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_bp [4];
    logic [31:0] m_ctrl, m_sts;
    logic        m_trap;

    always #2 clk = ~clk;

    bp_match_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
        .trap_req(trap_req)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [2:0] s);
        case (s)
            3'd0, 3'd1, 3'd2, 3'd3: return m_bp[s[1:0]];
            3'd6: return m_sts;
            3'd7: return m_ctrl;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_hit(input int i, input logic v,
                                   input logic [31:0] a, input logic [1:0] k);
        logic [1:0] ty, ln;
        logic [31:0] msk;
        logic tok;
        ty = m_ctrl[16+4*i +: 2];
        ln = m_ctrl[18+4*i +: 2];
        msk = (ln == 2'b01) ? 32'hFFFF_FFFE : (ln == 2'b11) ? 32'hFFFF_FFFC : 32'hFFFF_FFFF;
        case (ty)
            2'b00: tok = (k == 2'b00) && (ln == 2'b00);
            2'b01: tok = (k == 2'b01);
            2'b11: tok = (k == 2'b01) || (k == 2'b10);
            default: tok = 1'b0;
        endcase
        return v && (k != 2'b11) && ((a & msk) == (m_bp[i] & msk)) && tok;
    endfunction

    // One clock of stimulus, with the reference model advanced alongside.
    task automatic step(input logic wr, input logic rd, input logic [2:0] s,
                        input logic [31:0] wd, input logic v,
                        input logic [31:0] a, input logic [1:0] k, input string tag);
        logic gd, trip, tr;
        logic [31:0] n_ctrl, n_sts;
        logic [31:0] n_bp [4];
        @(negedge clk);
        check(tag, "trap_req", {31'b0, trap_req}, {31'b0, m_trap});
        reg_wr = wr; reg_rd = rd; reg_sel = s; reg_wdata = wd;
        acc_valid = v; acc_addr = a; acc_kind = k;
        #1;
        gd   = m_ctrl[13];
        trip = gd && (wr || rd);
        if (rd) check(tag, $sformatf("rdata[%0d]", s), reg_rdata, trip ? 32'h0 : m_read(s));
        n_ctrl = m_ctrl; n_sts = m_sts;
        for (int i = 0; i < 4; i++) n_bp[i] = m_bp[i];
        if (trip) begin
            n_sts[13] = 1'b1;
            n_ctrl[13] = 1'b0;
        end else if (wr) begin
            if (s < 3'd4) n_bp[s[1:0]] = wd;
            else if (s == 3'd6) n_sts = wd & 32'h0000_E00F;
            else if (s == 3'd7) n_ctrl = wd & 32'hFFFF_23FF;
        end
        tr = trip;
        for (int i = 0; i < 4; i++) begin
            if (m_hit(i, v, a, k)) begin
                n_sts[i] = 1'b1;
                if (m_ctrl[2*i] || m_ctrl[2*i+1]) tr = 1'b1;
            end
        end
        @(posedge clk);
        m_ctrl = n_ctrl; m_sts = n_sts; m_trap = tr;
        for (int i = 0; i < 4; i++) m_bp[i] = n_bp[i];
    endtask

    task automatic wreg(input logic [2:0] s, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, s, d, 1'b0, 32'h0, 2'b11, tag);
    endtask
    task automatic rreg(input logic [2:0] s, input string tag);
        step(1'b0, 1'b1, s, 32'h0, 1'b0, 32'h0, 2'b11, tag);
    endtask
    task automatic acc(input logic [31:0] a, input logic [1:0] k, input string tag);
        step(1'b0, 1'b0, 3'd0, 32'h0, 1'b1, a, k, tag);
    endtask
    task automatic idle(input string tag);
        step(1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 2'b11, tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        m_ctrl = '0; m_sts = '0; m_trap = 1'b0;
        for (int i = 0; i < 4; i++) m_bp[i] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 8; s++) rreg(3'(s), "R1");
        idle("R1");

        // R2: address registers and reserved indices
        wreg(3'd0, 32'h0000_1000, "R2");
        wreg(3'd1, 32'hDEAD_BEEF, "R2");
        wreg(3'd2, 32'h0000_0005, "R2");
        wreg(3'd3, 32'h8000_0003, "R2");
        wreg(3'd4, 32'hFFFF_FFFF, "R2");
        wreg(3'd5, 32'h1234_5678, "R2");
        for (int s = 0; s < 6; s++) rreg(3'(s), "R2");

        // R3 / R8: all-ones control sets protection; next access is refused
        wreg(3'd7, 32'hFFFF_FFFF, "R3");
        rreg(3'd7, "R8");
        rreg(3'd7, "R3");
        rreg(3'd6, "R8");
        // R8: a refused write changes nothing
        wreg(3'd7, 32'h0000_2000, "R8");
        wreg(3'd1, 32'h0BAD_0BAD, "R8");
        rreg(3'd1, "R8");
        rreg(3'd7, "R8");
        wreg(3'd7, 32'h0, "R3");
        wreg(3'd6, 32'h0, "R9");

        // R4: windows around address 5 for every length code
        foreach (m_bp[j]) begin end
        for (int ln = 0; ln < 4; ln++) begin
            wreg(3'd7, 32'h0000_0010 | (32'h3 << 24) | (32'(ln) << 26), "R4");
            for (int a = 3; a <= 8; a++) begin
                acc(32'(a), 2'b10, "R4");
                rreg(3'd6, "R4");
                wreg(3'd6, 32'h0, "R4");
            end
        end

        // R5: type and kind combinations on breakpoint 0 at 0x1000
        for (int ty = 0; ty < 4; ty++) begin
            for (int ln = 0; ln < 2; ln++) begin
                wreg(3'd7, 32'h1 | (32'(ty) << 16) | (32'(ln) << 18), "R5");
                for (int k = 0; k < 4; k++) begin
                    acc(32'h1001, 2'(k), "R5");
                    rreg(3'd6, "R5");
                    wreg(3'd6, 32'h0, "R5");
                end
            end
        end
        step(1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 32'h1000, 2'b01, "R5");

        // R6 / R7: flag without enable, sticky, then global and extra enables
        wreg(3'd7, 32'h0000_0300 | (32'h3 << 16), "R6");
        acc(32'h1000, 2'b01, "R6");
        idle("R7"); idle("R6"); idle("R6");
        rreg(3'd6, "R6");
        wreg(3'd7, 32'h0000_0002 | (32'h3 << 16), "R7");
        acc(32'h1000, 2'b10, "R7");
        acc(32'h1000, 2'b10, "R7");
        idle("R7"); idle("R7");

        // R9: status write races a hit
        step(1'b1, 1'b0, 3'd6, 32'hFFFF_FFFF, 1'b1, 32'h1000, 2'b01, "R9");
        rreg(3'd6, "R9");
        step(1'b1, 1'b0, 3'd6, 32'h0, 1'b1, 32'h1000, 2'b01, "R9");
        rreg(3'd6, "R9");

        // R7: random traffic, protection bit kept clear
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[2:0] == 3'd0)
                wreg(3'd7, $urandom & 32'hFFFF_DFFF, "R7");
            else if (r[2:0] == 3'd1)
                wreg(3'(r[5:4]), 32'h0000_1000 | ($urandom & 32'hF), "R7");
            else if (r[2:0] == 3'd2)
                rreg(3'(r[8:6]), "R7");
            else if (r[2:0] == 3'd3)
                wreg(3'd6, $urandom, "R9");
            else
                acc(32'h0000_1000 | ($urandom & 32'hF), 2'($urandom), "R7");
        end
        idle("R7"); idle("R7");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule